// File: doc/BRIEF.md
# Host Address Window Decoder

This block sits on the host side of a sideband peripheral link. It decides, in the same cycle, whether a host I/O or memory cycle belongs to the attached peripheral. The cycle's type, address and a valid strobe come in, and a hit flag comes out. The decision comes from a small configuration register file, which holds three sources of decode:

- Fixed legacy port decodes. Two of them cover a pair of ports with one shared enable.
- A parameterized set of generic I/O windows.
- A parameterized set of generic memory windows.

Each generic window has a base, a size field that stores the length minus one, and its own enable bit in a common enable register. All windows are compared in parallel. When none of them claims a cycle, a subtractive option can still take it, provided no other agent on the host fabric has claimed it. The block reports that subtractive hit separately, together with a programmable target-select code. Configuration uses a plain word-addressed write strobe and a combinational read port.

Top module: `addr_window_decoder`

## Requirements
- R1: Enable register (offset 0x00) bit 0 makes an I/O cycle to port 0x0080 hit. Port 0x0081 does not hit, and neither does a memory cycle at address 0x80.
- R2: Enable bit 1 makes both port 0x0060 and port 0x0064 hit, but not port 0x0062 or 0x0065. Enable bit 2 makes both port 0x002E and port 0x002F hit, but not port 0x002D or 0x0030.
- R3: I/O window i is held at offset 0x10+4*i, with its base in bits [15:0] and its length minus one in bits [23:16]. An I/O cycle hits the window when its address bits [15:0] lie in base..base+size inclusive. Memory cycles never hit an I/O window.
- R4: Memory window j has its 32-bit base at offset 0x40+8*j and its length minus one in bits [15:0] of offset 0x44+8*j. A memory cycle hits the window when its address lies in base..base+size inclusive. I/O cycles never hit a memory window.
- R5: I/O window i is enabled by bit 8+i of the enable register, and memory window j by bit 16+j. A window whose enable bit is clear never hits, whatever its base and size hold.
- R6: Control register (offset 0x04) bit 2 enables subtractive decode. When it is set, a valid cycle that no window or legacy decode claims, and that cyc_claimed does not mark, sets both dec_hit and dec_subtractive. When cyc_claimed is high, or bit 2 is clear, such a cycle does not hit.
- R7: dec_sub_target always shows control bits [4:3]. A positive decode hit keeps dec_subtractive low.
- R8: A window whose inclusive end passes the top of its address space ends at the top address and does not wrap around to address 0.
- R9: After reset every register reads zero and nothing hits. Each register field reads back exactly what was written. Unmapped offsets and unused bits read zero, and registers hold their value when no write is made.
- R10: When cyc_valid is low, dec_hit and dec_subtractive are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Register clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_addr | input | 8 | Configuration byte offset, for both write and read |
| cfg_wdata | input | 32 | Configuration write data |
| cfg_rdata | output | 32 | Combinational read data at cfg_addr |
| cyc_valid | input | 1 | Host cycle present |
| cyc_is_mem | input | 1 | 1 = memory cycle, 0 = I/O cycle |
| cyc_addr | input | 32 | Cycle address (I/O cycles use bits [15:0]) |
| cyc_claimed | input | 1 | Another agent has positively claimed this cycle |
| dec_hit | output | 1 | Cycle goes to the peripheral |
| dec_subtractive | output | 1 | Hit came from the subtractive path |
| dec_sub_target | output | 2 | Subtractive target-select code |

## Verification
Some properties are checked on every clock edge:

- Window hits never cross cycle type.
- A disabled window never reports a match.
- A subtractive hit only appears on an unclaimed miss with the feature on.
- Nothing hits without cyc_valid, and port 0x80 always hits when it is enabled.
- Enable bits stay put without a write.

Other behaviour only shows up in the bench's scenarios:

- Exact inclusive bounds at base-1, base, base+size and base+size+1 for every window, under random bases and sizes.
- The shared port-pair enables.
- The end-of-space clipping.
- Register readback.

// File: rtl/awd_pkg.sv
package awd_pkg;
  localparam int REG_AW  = 8;
  localparam int DATA_W  = 32;
  localparam int IO_AW   = 16;
  localparam int IO_SW   = 8;
  localparam int MEM_AW  = 32;
  localparam int MEM_SW  = 16;

  localparam logic [REG_AW-1:0] OFF_ENABLE  = 8'h00;
  localparam logic [REG_AW-1:0] OFF_CTRL    = 8'h04;
  localparam logic [REG_AW-1:0] OFF_IO_WIN  = 8'h10;
  localparam logic [REG_AW-1:0] OFF_MEM_WIN = 8'h40;

  localparam int EN_LEG_LSB   = 0;
  localparam int EN_IO_LSB    = 8;
  localparam int EN_MEM_LSB   = 16;
  localparam int CTRL_SUB_BIT = 2;
  localparam int CTRL_TGT_LSB = 3;
  localparam int LEG_COUNT    = 3;

  localparam logic [IO_AW-1:0] PORT_POST     = 16'h0080;
  localparam logic [IO_AW-1:0] PORT_KBC_DATA = 16'h0060;
  localparam logic [IO_AW-1:0] PORT_KBC_CMD  = 16'h0064;
  localparam logic [IO_AW-1:0] PORT_SIO_IDX  = 16'h002E;
  localparam logic [IO_AW-1:0] PORT_SIO_DAT  = 16'h002F;

  typedef struct packed {
    logic       sub_en;
    logic [1:0] sub_tgt;
  } ctrl_t;

  function automatic logic [REG_AW-1:0] io_win_off(input int idx);
    return OFF_IO_WIN + REG_AW'(4 * idx);
  endfunction

  function automatic logic [REG_AW-1:0] mem_base_off(input int idx);
    return OFF_MEM_WIN + REG_AW'(8 * idx);
  endfunction

  function automatic logic [REG_AW-1:0] mem_size_off(input int idx);
    return OFF_MEM_WIN + REG_AW'(8 * idx + 4);
  endfunction
endpackage

// File: rtl/awd_win_cmp.sv
module awd_win_cmp #(
  parameter int AW = 16,
  parameter int SW = 8
) (
  input  logic          enable,
  input  logic [AW-1:0] addr,
  input  logic [AW-1:0] base,
  input  logic [SW-1:0] size_m1,
  output logic          match
);
  localparam int EW = AW + 1;

  logic [EW-1:0] last_addr;
  logic          above_base;
  logic          below_end;

  // The end is one bit wider than the address, so it never wraps past the top.
  assign last_addr  = {1'b0, base} + EW'(size_m1);
  assign above_base = (addr >= base);
  assign below_end  = ({1'b0, addr} <= last_addr);
  assign match      = enable & above_base & below_end;
endmodule

// File: rtl/awd_legacy.sv
module awd_legacy
  import awd_pkg::*;
(
  input  logic                 io_cycle,
  input  logic [IO_AW-1:0]     port,
  input  logic [LEG_COUNT-1:0] leg_en,
  output logic [LEG_COUNT-1:0] leg_hit
);
  logic post_port;
  logic kbc_port;
  logic sio_port;

  assign post_port = (port == PORT_POST);
  assign kbc_port  = (port == PORT_KBC_DATA) | (port == PORT_KBC_CMD);
  assign sio_port  = (port == PORT_SIO_IDX)  | (port == PORT_SIO_DAT);

  assign leg_hit[0] = io_cycle & leg_en[0] & post_port;
  assign leg_hit[1] = io_cycle & leg_en[1] & kbc_port;
  assign leg_hit[2] = io_cycle & leg_en[2] & sio_port;
endmodule

// File: rtl/awd_regs.sv
module awd_regs
  import awd_pkg::*;
#(
  parameter int N_IO  = 4,
  parameter int N_MEM = 4
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          cfg_wr,
  input  logic [REG_AW-1:0]             cfg_addr,
  input  logic [DATA_W-1:0]             cfg_wdata,
  output logic [DATA_W-1:0]             cfg_rdata,
  output logic [LEG_COUNT-1:0]          leg_en,
  output logic [N_IO-1:0]               io_en,
  output logic [N_MEM-1:0]              mem_en,
  output logic [N_IO-1:0][IO_AW-1:0]    io_base,
  output logic [N_IO-1:0][IO_SW-1:0]    io_size,
  output logic [N_MEM-1:0][MEM_AW-1:0]  mem_base,
  output logic [N_MEM-1:0][MEM_SW-1:0]  mem_size,
  output ctrl_t                         ctrl
);
  logic sel_enable;
  logic sel_ctrl;
  logic [N_IO-1:0]  sel_io;
  logic [N_MEM-1:0] sel_mbase;
  logic [N_MEM-1:0] sel_msize;

  assign sel_enable = (cfg_addr == OFF_ENABLE);
  assign sel_ctrl   = (cfg_addr == OFF_CTRL);

  for (genvar gi = 0; gi < N_IO; gi++) begin : g_io_sel
    assign sel_io[gi] = (cfg_addr == io_win_off(gi));
  end
  for (genvar gm = 0; gm < N_MEM; gm++) begin : g_mem_sel
    assign sel_mbase[gm] = (cfg_addr == mem_base_off(gm));
    assign sel_msize[gm] = (cfg_addr == mem_size_off(gm));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      leg_en <= '0;
      io_en  <= '0;
      mem_en <= '0;
      ctrl   <= '0;
    end else if (cfg_wr) begin
      if (sel_enable) begin
        leg_en <= cfg_wdata[EN_LEG_LSB +: LEG_COUNT];
        io_en  <= cfg_wdata[EN_IO_LSB  +: N_IO];
        mem_en <= cfg_wdata[EN_MEM_LSB +: N_MEM];
      end
      if (sel_ctrl) begin
        ctrl.sub_en  <= cfg_wdata[CTRL_SUB_BIT];
        ctrl.sub_tgt <= cfg_wdata[CTRL_TGT_LSB +: 2];
      end
    end
  end

  for (genvar gi = 0; gi < N_IO; gi++) begin : g_io_reg
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        io_base[gi] <= '0;
        io_size[gi] <= '0;
      end else if (cfg_wr && sel_io[gi]) begin
        io_base[gi] <= cfg_wdata[IO_AW-1:0];
        io_size[gi] <= cfg_wdata[IO_AW +: IO_SW];
      end
    end
  end

  for (genvar gm = 0; gm < N_MEM; gm++) begin : g_mem_reg
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        mem_base[gm] <= '0;
        mem_size[gm] <= '0;
      end else if (cfg_wr) begin
        if (sel_mbase[gm]) mem_base[gm] <= cfg_wdata[MEM_AW-1:0];
        if (sel_msize[gm]) mem_size[gm] <= cfg_wdata[MEM_SW-1:0];
      end
    end
  end

  always_comb begin
    cfg_rdata = '0;
    if (sel_enable) begin
      cfg_rdata[EN_LEG_LSB +: LEG_COUNT] = leg_en;
      cfg_rdata[EN_IO_LSB  +: N_IO]      = io_en;
      cfg_rdata[EN_MEM_LSB +: N_MEM]     = mem_en;
    end
    if (sel_ctrl) begin
      cfg_rdata[CTRL_SUB_BIT]       = ctrl.sub_en;
      cfg_rdata[CTRL_TGT_LSB +: 2]  = ctrl.sub_tgt;
    end
    for (int i = 0; i < N_IO; i++) begin
      if (sel_io[i]) begin
        cfg_rdata[IO_AW-1:0]     = io_base[i];
        cfg_rdata[IO_AW +: IO_SW] = io_size[i];
      end
    end
    for (int j = 0; j < N_MEM; j++) begin
      if (sel_mbase[j]) cfg_rdata[MEM_AW-1:0] = mem_base[j];
      if (sel_msize[j]) cfg_rdata[MEM_SW-1:0] = mem_size[j];
    end
  end

  logic unused_wdata_bits;
  assign unused_wdata_bits = ^cfg_wdata;
endmodule

// File: rtl/addr_window_decoder.sv
module addr_window_decoder
  import awd_pkg::*;
#(
  parameter int N_IO  = 4,
  parameter int N_MEM = 4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cfg_wr,
  input  logic [7:0]  cfg_addr,
  input  logic [31:0] cfg_wdata,
  output logic [31:0] cfg_rdata,
  input  logic        cyc_valid,
  input  logic        cyc_is_mem,
  input  logic [31:0] cyc_addr,
  input  logic        cyc_claimed,
  output logic        dec_hit,
  output logic        dec_subtractive,
  output logic [1:0]  dec_sub_target
);
  logic [LEG_COUNT-1:0]         leg_en;
  logic [N_IO-1:0]              io_en;
  logic [N_MEM-1:0]             mem_en;
  logic [N_IO-1:0][IO_AW-1:0]   io_base;
  logic [N_IO-1:0][IO_SW-1:0]   io_size;
  logic [N_MEM-1:0][MEM_AW-1:0] mem_base;
  logic [N_MEM-1:0][MEM_SW-1:0] mem_size;
  ctrl_t                        ctrl;

  logic                 io_cycle;
  logic                 mem_cycle;
  logic [LEG_COUNT-1:0] legacy_hit;
  logic [N_IO-1:0]      io_win_hit;
  logic [N_MEM-1:0]     mem_win_hit;
  logic                 pos_hit;
  logic                 sub_hit;

  awd_regs #(.N_IO(N_IO), .N_MEM(N_MEM)) u_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .cfg_wr   (cfg_wr),
    .cfg_addr (cfg_addr),
    .cfg_wdata(cfg_wdata),
    .cfg_rdata(cfg_rdata),
    .leg_en   (leg_en),
    .io_en    (io_en),
    .mem_en   (mem_en),
    .io_base  (io_base),
    .io_size  (io_size),
    .mem_base (mem_base),
    .mem_size (mem_size),
    .ctrl     (ctrl)
  );

  assign io_cycle  = cyc_valid & ~cyc_is_mem;
  assign mem_cycle = cyc_valid &  cyc_is_mem;

  awd_legacy u_legacy (
    .io_cycle(io_cycle),
    .port    (cyc_addr[IO_AW-1:0]),
    .leg_en  (leg_en),
    .leg_hit (legacy_hit)
  );

  for (genvar gi = 0; gi < N_IO; gi++) begin : g_io_cmp
    awd_win_cmp #(.AW(IO_AW), .SW(IO_SW)) u_cmp (
      .enable (io_cycle & io_en[gi]),
      .addr   (cyc_addr[IO_AW-1:0]),
      .base   (io_base[gi]),
      .size_m1(io_size[gi]),
      .match  (io_win_hit[gi])
    );
  end

  for (genvar gm = 0; gm < N_MEM; gm++) begin : g_mem_cmp
    awd_win_cmp #(.AW(MEM_AW), .SW(MEM_SW)) u_cmp (
      .enable (mem_cycle & mem_en[gm]),
      .addr   (cyc_addr),
      .base   (mem_base[gm]),
      .size_m1(mem_size[gm]),
      .match  (mem_win_hit[gm])
    );
  end

  assign pos_hit = (|legacy_hit) | (|io_win_hit) | (|mem_win_hit);
  assign sub_hit = cyc_valid & ctrl.sub_en & ~pos_hit & ~cyc_claimed;

  assign dec_hit         = pos_hit | sub_hit;
  assign dec_subtractive = sub_hit;
  assign dec_sub_target  = ctrl.sub_tgt;
endmodule

// File: rtl/awd_checker.sv
module awd_checker #(
  parameter int N_IO  = 4,
  parameter int N_MEM = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cfg_wr,
  input logic             cyc_valid,
  input logic             cyc_is_mem,
  input logic [31:0]      cyc_addr,
  input logic             cyc_claimed,
  input logic             dec_hit,
  input logic             dec_subtractive,
  input logic [2:0]       leg_en,
  input logic [2:0]       legacy_hit,
  input logic [N_IO-1:0]  io_en,
  input logic [N_MEM-1:0] mem_en,
  input logic [N_IO-1:0]  io_win_hit,
  input logic [N_MEM-1:0] mem_win_hit
);
  AST_PORT80_CLAIMED: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc_valid && !cyc_is_mem && cyc_addr[15:0] == 16'h0080 && leg_en[0]) |-> dec_hit); // R1
  AST_IO_WIN_IO_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    ((|io_win_hit) || (|legacy_hit)) |-> (cyc_valid && !cyc_is_mem)); // R3
  AST_MEM_WIN_MEM_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    (|mem_win_hit) |-> (cyc_valid && cyc_is_mem)); // R4
  AST_DISABLED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    ((io_win_hit & ~io_en) == '0) && ((mem_win_hit & ~mem_en) == '0)); // R5
  AST_SUB_ONLY_ON_MISS: assert property (@(posedge clk) disable iff (!rst_n)
    dec_subtractive |-> (dec_hit && !cyc_claimed && io_win_hit == '0
                         && mem_win_hit == '0 && legacy_hit == '0)); // R6
  AST_ENABLES_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_wr |=> ($stable(io_en) && $stable(mem_en) && $stable(leg_en))); // R9
  AST_IDLE_NO_HIT: assert property (@(posedge clk) disable iff (!rst_n)
    !cyc_valid |-> (!dec_hit && !dec_subtractive)); // R10
endmodule

bind addr_window_decoder awd_checker #(.N_IO(N_IO), .N_MEM(N_MEM)) u_awd_checker (
  .clk            (clk),
  .rst_n          (rst_n),
  .cfg_wr         (cfg_wr),
  .cyc_valid      (cyc_valid),
  .cyc_is_mem     (cyc_is_mem),
  .cyc_addr       (cyc_addr),
  .cyc_claimed    (cyc_claimed),
  .dec_hit        (dec_hit),
  .dec_subtractive(dec_subtractive),
  .leg_en         (leg_en),
  .legacy_hit     (legacy_hit),
  .io_en          (io_en),
  .mem_en         (mem_en),
  .io_win_hit     (io_win_hit),
  .mem_win_hit    (mem_win_hit)
);

// File: tb/tb_addr_window_decoder.sv
`timescale 1ns/1ps
module tb_addr_window_decoder;
  localparam int NI = 4;
  localparam int NM = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_wr = 1'b0;
  logic [7:0]  cfg_addr = '0;
  logic [31:0] cfg_wdata = '0;
  logic [31:0] cfg_rdata;
  logic        cyc_valid = 1'b0;
  logic        cyc_is_mem = 1'b0;
  logic [31:0] cyc_addr = '0;
  logic        cyc_claimed = 1'b0;
  logic        dec_hit;
  logic        dec_subtractive;
  logic [1:0]  dec_sub_target;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  // Bench-side copy of the programmed configuration
  logic [2:0]  m_leg = '0;
  logic [NI-1:0] m_io_en = '0;
  logic [NM-1:0] m_mem_en = '0;
  logic [15:0] m_io_base [NI];
  logic [7:0]  m_io_size [NI];
  logic [31:0] m_mem_base[NM];
  logic [15:0] m_mem_size[NM];
  logic        m_sub = 1'b0;
  logic [1:0]  m_tgt = '0;

  always #4 clk = ~clk;

  addr_window_decoder #(.N_IO(NI), .N_MEM(NM)) dut (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .cyc_valid(cyc_valid),
    .cyc_is_mem(cyc_is_mem), .cyc_addr(cyc_addr), .cyc_claimed(cyc_claimed),
    .dec_hit(dec_hit), .dec_subtractive(dec_subtractive),
    .dec_sub_target(dec_sub_target)
  );

  function automatic logic in_span(longint a, longint b, longint sz);
    return (a >= b) && (a <= b + sz);
  endfunction

  // returns {hit, subtractive}
  function automatic logic [1:0] expect_dec(logic v, logic m, logic [31:0] a, logic cl);
    logic pos = 1'b0;
    logic sub;
    if (v && !m) begin
      if (m_leg[0] && a[15:0] == 16'h0080) pos = 1'b1;
      if (m_leg[1] && (a[15:0] == 16'h0060 || a[15:0] == 16'h0064)) pos = 1'b1;
      if (m_leg[2] && (a[15:0] == 16'h002E || a[15:0] == 16'h002F)) pos = 1'b1;
      for (int i = 0; i < NI; i++)
        if (m_io_en[i] && in_span(longint'(a[15:0]), longint'(m_io_base[i]), longint'(m_io_size[i])))
          pos = 1'b1;
    end
    if (v && m) begin
      for (int j = 0; j < NM; j++)
        if (m_mem_en[j] && in_span(longint'(a), longint'(m_mem_base[j]), longint'(m_mem_size[j])))
          pos = 1'b1;
    end
    sub = v && !pos && !cl && m_sub;
    return {pos | sub, sub};
  endfunction

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    cfg_addr = a; cfg_wdata = d; cfg_wr = 1'b1;
    @(posedge clk); #1;
    cfg_wr = 1'b0;
    if (a == 8'h00) begin
      m_leg = d[2:0]; m_io_en = d[8 +: NI]; m_mem_en = d[16 +: NM];
    end
    if (a == 8'h04) begin m_sub = d[2]; m_tgt = d[4:3]; end
    for (int i = 0; i < NI; i++)
      if (a == 8'(8'h10 + 4*i)) begin m_io_base[i] = d[15:0]; m_io_size[i] = d[23:16]; end
    for (int j = 0; j < NM; j++) begin
      if (a == 8'(8'h40 + 8*j)) m_mem_base[j] = d;
      if (a == 8'(8'h44 + 8*j)) m_mem_size[j] = d[15:0];
    end
  endtask

  task automatic chk_rd(input logic [7:0] a, input logic [31:0] exp, input string req);
    cfg_addr = a; #1;
    checks++;
    if (cfg_rdata !== exp) begin
      fails++;
      $display("FAIL %s read 0x%02h actual=%08h expected=%08h", req, a, cfg_rdata, exp);
    end
  endtask

  task automatic chk_dec(input logic v, input logic m, input logic [31:0] a,
                         input logic cl, input string req);
    logic [1:0] e;
    cyc_valid = v; cyc_is_mem = m; cyc_addr = a; cyc_claimed = cl;
    #2;
    e = expect_dec(v, m, a, cl);
    checks++;
    if (dec_hit !== e[1] || dec_subtractive !== e[0] || dec_sub_target !== m_tgt) begin
      fails++;
      $display("FAIL %s addr=%08h mem=%0b actual hit/sub/tgt=%0b%0b%0d expected=%0b%0b%0d",
               req, a, m, dec_hit, dec_subtractive, dec_sub_target, e[1], e[0], m_tgt);
    end
    #2;
  endtask

  task automatic chk_io_bounds(input int i, input string req);
    chk_dec(1, 0, {16'h0, 16'(m_io_base[i] - 16'd1)}, 0, req);
    chk_dec(1, 0, {16'h0, m_io_base[i]}, 0, req);
    chk_dec(1, 0, {16'h0, 16'(m_io_base[i] + 16'(m_io_size[i]))}, 0, req);
    chk_dec(1, 0, {16'h0, 16'(m_io_base[i] + 16'(m_io_size[i]) + 16'd1)}, 0, req);
    chk_dec(1, 1, {16'h0, m_io_base[i]}, 0, req);
  endtask

  task automatic chk_mem_bounds(input int j, input string req);
    chk_dec(1, 1, m_mem_base[j] - 32'd1, 0, req);
    chk_dec(1, 1, m_mem_base[j], 0, req);
    chk_dec(1, 1, m_mem_base[j] + 32'(m_mem_size[j]), 0, req);
    chk_dec(1, 1, m_mem_base[j] + 32'(m_mem_size[j]) + 32'd1, 0, req);
    chk_dec(1, 0, m_mem_base[j], 0, req);
  endtask

  initial begin
    logic [31:0] en_word;
    int unsigned seed_pick;
    for (int i = 0; i < NI; i++) begin m_io_base[i] = '0; m_io_size[i] = '0; end
    for (int j = 0; j < NM; j++) begin m_mem_base[j] = '0; m_mem_size[j] = '0; end
    seed_pick = $urandom(32'h00C0FFEE);
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    #2;

    // R9: reset state
    chk_rd(8'h00, 32'h0, "R9");
    chk_rd(8'h04, 32'h0, "R9");
    chk_rd(8'h10, 32'h0, "R9");
    chk_rd(8'h44, 32'h0, "R9");
    chk_dec(1, 0, 32'h80, 0, "R9");
    chk_dec(1, 1, 32'h0, 0, "R9");

    // R1: single post port
    wr(8'h00, 32'h1);
    chk_dec(1, 0, 32'h80, 0, "R1");
    chk_dec(1, 0, 32'h81, 0, "R1");
    chk_dec(1, 1, 32'h80, 0, "R1");
    chk_dec(1, 0, 32'h60, 0, "R1");
    // R10: idle
    chk_dec(0, 0, 32'h80, 0, "R10");

    // R2: shared pair enables
    wr(8'h00, 32'h6);
    chk_dec(1, 0, 32'h60, 0, "R2");
    chk_dec(1, 0, 32'h64, 0, "R2");
    chk_dec(1, 0, 32'h62, 0, "R2");
    chk_dec(1, 0, 32'h65, 0, "R2");
    chk_dec(1, 0, 32'h2E, 0, "R2");
    chk_dec(1, 0, 32'h2F, 0, "R2");
    chk_dec(1, 0, 32'h2D, 0, "R2");
    chk_dec(1, 0, 32'h30, 0, "R2");
    chk_dec(1, 0, 32'h80, 0, "R2");
    chk_rd(8'h00, 32'h6, "R9");

    // R3/R4/R5: random windows with boundary checks
    for (int round = 0; round < 6; round++) begin
      en_word = {8'h0, 4'h0, 4'($urandom), 4'h0, 4'($urandom), 8'h0};
      if (round == 0) en_word = 32'h000F_0F00;
      for (int i = 0; i < NI; i++) begin
        logic [31:0] d;
        d = {8'h0, 8'($urandom), 16'($urandom)};
        wr(8'(8'h10 + 4*i), d);
        chk_rd(8'(8'h10 + 4*i), d, "R9");
      end
      for (int j = 0; j < NM; j++) begin
        logic [31:0] b;
        logic [15:0] s;
        b = $urandom; s = 16'($urandom);
        wr(8'(8'h40 + 8*j), b);
        wr(8'(8'h44 + 8*j), {16'h0, s});
        chk_rd(8'(8'h40 + 8*j), b, "R9");
        chk_rd(8'(8'h44 + 8*j), {16'h0, s}, "R9");
      end
      wr(8'h00, en_word);
      chk_rd(8'h00, en_word, "R5");
      for (int i = 0; i < NI; i++) chk_io_bounds(i, m_io_en[i] ? "R3" : "R5");
      for (int j = 0; j < NM; j++) chk_mem_bounds(j, m_mem_en[j] ? "R4" : "R5");
      for (int k = 0; k < 30; k++) begin
        logic [31:0] a;
        logic mm;
        mm = 1'($urandom);
        a = mm ? $urandom : {16'h0, 16'($urandom)};
        chk_dec(1, mm, a, 0, "R3");
      end
    end

    // R5: directed disabled window
    wr(8'h00, 32'h0);
    wr(8'h10, 32'h000F_1000);
    chk_dec(1, 0, 32'h1000, 0, "R5");
    chk_dec(1, 0, 32'h100F, 0, "R5");
    wr(8'h00, 32'h0000_0100);
    chk_dec(1, 0, 32'h100F, 0, "R3");
    chk_dec(1, 0, 32'h1010, 0, "R3");

    // R8: no wrap at top of space
    wr(8'h14, 32'h00FF_FFF0);
    wr(8'h40, 32'hFFFF_FF00);
    wr(8'h44, 32'h0000_FFFF);
    wr(8'h00, 32'h0001_0200);
    chk_dec(1, 0, 32'hFFFF, 0, "R8");
    chk_dec(1, 0, 32'h0000, 0, "R8");
    chk_dec(1, 0, 32'h00EE, 0, "R8");
    chk_dec(1, 1, 32'hFFFF_FFFF, 0, "R8");
    chk_dec(1, 1, 32'h0000_0000, 0, "R8");
    chk_dec(1, 1, 32'h0000_FEFF, 0, "R8");

    // R6/R7: subtractive path
    wr(8'h04, 32'h0000_0014);
    chk_rd(8'h04, 32'h14, "R9");
    chk_dec(1, 1, 32'h1234_5678, 0, "R6");
    chk_dec(1, 1, 32'h1234_5678, 1, "R6");
    chk_dec(1, 0, 32'h0300, 0, "R6");
    chk_dec(0, 0, 32'h0300, 0, "R10");
    chk_dec(1, 0, 32'hFFFF, 0, "R7");
    chk_dec(1, 0, 32'hFFFF, 1, "R7");
    wr(8'h04, 32'hFFFF_FFFF);
    chk_rd(8'h04, 32'h1C, "R9");
    chk_dec(1, 1, 32'h0000_1000, 0, "R7");
    wr(8'h04, 32'h0000_0008);
    chk_dec(1, 1, 32'h1234_5678, 0, "R6");
    chk_rd(8'h08, 32'h0, "R9");
    chk_rd(8'h3C, 32'h0, "R9");

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule